// File: doc/BRIEF.md
# I2C Master Word Shifter

This block moves one data word at a time between a single bus master and an I2C slave, once the bus has already been claimed. The host sets a 3-bit word-length field, an acknowledge-slot enable and a direction bit. It then starts each word through the data port. In transmit direction, a write of the data port shifts the word out on SDA. In receive direction, a read of the data port returns the word captured so far and, in the same cycle, starts clocking the next word in. Because nothing has been captured before the first read, that first read is a dummy.

After every word the block raises a pending level and a one-cycle interrupt pulse. It then parks SCL low until the host services the data port. Each SCL low phase and each high phase lasts a programmable number of clock cycles. The acknowledge slot can be dropped for a single word, which ends a read without an acknowledge. A following 1-bit transfer then supplies the final bus bit. START, STOP, arbitration, slave mode and slave clock stretching are not part of this block.

Top module: `i2c_byte_master`

## Requirements
- R1: After reset, scl_o is 1 (released), sda_oe_o is 0, and busy_o, pend_o and irq_o are all 0.
- R2: The word-length field bit_cnt_i is sampled when a transfer starts. A value of 0 gives 8 data clock pulses, and a value k from 1 to 7 gives k data clock pulses.
- R3: When ack_en_i is 1 at the start of a transfer, exactly one more SCL pulse follows the data pulses. When it is 0, no extra pulse is generated.
- R4: With tx_mode_i=1, a wr_i pulse while not busy starts a transfer. Data leaves most significant bit first, starting at wdata_i[7]. A 0 bit is driven with sda_oe_o=1 and a 1 bit with sda_oe_o=0.
- R5: In transmit direction the master releases SDA during the acknowledge slot. The SDA level seen at the end of that slot is presented on lrb_o.
- R6: With tx_mode_i=0, an rd_i pulse while not busy starts a reception. In that same cycle, rdata_o holds the previous word, which is 0 after reset. Received bits enter at rdata_o[0], and earlier bits move toward the MSB.
- R7: In receive direction, the master drives SDA low (sda_oe_o=1) throughout the acknowledge slot.
- R8: When the last pulse of a transfer ends, pend_o rises and irq_o pulses for exactly one cycle. SCL then stays low and pend_o stays high until the next starting wr_i or rd_i.
- R9: While busy, each SCL high phase and each SCL low phase that follows a falling edge lasts div_i cycles. A div_i value of 0 acts as 1.
- R10: sda_oe_o never changes while SCL stays high during a transfer.
- R11: A wr_i or rd_i pulse during a transfer has no effect. So does a wr_i in receive direction, and so does an rd_i in transmit direction.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| div_i | input | DIV_W | SCL half-period in clock cycles (0 acts as 1) |
| bit_cnt_i | input | BC_W | Word length: 0 means a full word, k means k bits |
| ack_en_i | input | 1 | Append an acknowledge slot to the word |
| tx_mode_i | input | 1 | 1 = transmit, 0 = receive |
| wr_i | input | 1 | Data port write strobe |
| wdata_i | input | 2**BC_W | Word to transmit |
| rd_i | input | 1 | Data port read strobe |
| rdata_o | output | 2**BC_W | Received word |
| scl_o | output | 1 | SCL level, 1 = released |
| sda_oe_o | output | 1 | 1 = pull SDA low |
| sda_i | input | 1 | SDA bus level |
| busy_o | output | 1 | Transfer in progress |
| pend_o | output | 1 | Word done, waiting for service |
| irq_o | output | 1 | One-cycle completion pulse |
| lrb_o | output | 1 | Last SDA level sampled |

## Verification
Transmit words with mixed bit values are sent with both an acknowledging slave and a non-acknowledging slave. This separates a correct MSB-first shift and acknowledge capture from a swapped order or a stuck level. Short words of 3 and 1 bits, and words with and without the acknowledge slot, show that the pulse count follows the length field rather than a fixed count. A chain of receptions with different slave words shows that each read returns the previous word, including the zero dummy. Strobes in the wrong direction or during a transfer, and a zero divider, cover the start qualification and the phase-length floor.

// File: rtl/i2cbe_pkg.sv
package i2cbe_pkg;
  typedef enum logic [1:0] {
    ST_IDLE,
    ST_LOW,
    ST_HIGH,
    ST_HOLD
  } phase_e;
endpackage

// File: rtl/i2cbe_phase_timer.sv
module i2cbe_phase_timer #(
  parameter int DIV_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             run_i,
  input  logic [DIV_W-1:0] div_i,
  output logic             tick_o
);
  logic [DIV_W-1:0] cnt_q;
  logic [DIV_W-1:0] lim;

  assign lim    = (div_i == '0) ? '0 : div_i - DIV_W'(1);
  assign tick_o = run_i && (cnt_q >= lim);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)               cnt_q <= '0;
    else if (!run_i || tick_o) cnt_q <= '0;
    else                       cnt_q <= cnt_q + DIV_W'(1);
  end

  p_tick_clears_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tick_o |=> (cnt_q == '0));
  p_idle_clear_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !run_i |=> (cnt_q == '0));
endmodule

// File: rtl/i2cbe_shifter.sv
module i2cbe_shifter #(
  parameter int DW = 8
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          load_i,
  input  logic [DW-1:0] load_data_i,
  input  logic          shift_i,
  input  logic          sample_i,
  input  logic          bit_i,
  output logic          tx_msb_o,
  output logic [DW-1:0] rx_data_o
);
  logic [DW-1:0] tx_q;
  logic [DW-1:0] rx_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      tx_q <= '0;
    else if (load_i)  tx_q <= load_data_i;
    else if (shift_i) tx_q <= {tx_q[DW-2:0], 1'b0};
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)       rx_q <= '0;
    else if (sample_i) rx_q <= {rx_q[DW-2:0], bit_i};
  end

  assign tx_msb_o  = tx_q[DW-1];
  assign rx_data_o = rx_q;

  p_load_msb_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    load_i |=> (tx_msb_o == $past(load_data_i[DW-1])));
  p_rx_shift_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sample_i |=> (rx_data_o[0] == $past(bit_i)));
endmodule

// File: rtl/i2c_byte_master.sv
module i2c_byte_master
  import i2cbe_pkg::*;
#(
  parameter int DIV_W = 8,
  parameter int BC_W  = 3
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic [DIV_W-1:0]      div_i,
  input  logic [BC_W-1:0]       bit_cnt_i,
  input  logic                  ack_en_i,
  input  logic                  tx_mode_i,
  input  logic                  wr_i,
  input  logic [(1<<BC_W)-1:0]  wdata_i,
  input  logic                  rd_i,
  output logic [(1<<BC_W)-1:0]  rdata_o,
  output logic                  scl_o,
  output logic                  sda_oe_o,
  input  logic                  sda_i,
  output logic                  busy_o,
  output logic                  pend_o,
  output logic                  irq_o,
  output logic                  lrb_o
);
  localparam int DW     = 1 << BC_W;
  localparam int SLOT_W = $clog2(DW + 2);

  phase_e            st_q;
  logic [SLOT_W-1:0] slots_q;
  logic [SLOT_W-1:0] nb;
  logic              mode_q, ack_q, pend_q, irq_q, lrb_q;
  logic              tick, start, last_slot, ack_slot, hi_end, tx_msb;

  // word length: zero code selects the full word
  assign nb        = (bit_cnt_i == '0) ? SLOT_W'(DW) : SLOT_W'(bit_cnt_i);
  assign start     = (st_q == ST_IDLE || st_q == ST_HOLD) && (tx_mode_i ? wr_i : rd_i);
  assign busy_o    = (st_q == ST_LOW) || (st_q == ST_HIGH);
  assign last_slot = (slots_q == SLOT_W'(1));
  assign ack_slot  = ack_q && last_slot;
  assign hi_end    = (st_q == ST_HIGH) && tick;
  assign scl_o     = (st_q == ST_IDLE) || (st_q == ST_HIGH);
  assign sda_oe_o  = busy_o && (ack_slot ? !mode_q : (mode_q && !tx_msb));
  assign pend_o    = pend_q;
  assign irq_o     = irq_q;
  assign lrb_o     = lrb_q;

  i2cbe_phase_timer #(.DIV_W(DIV_W)) u_timer (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .run_i  (busy_o),
    .div_i  (div_i),
    .tick_o (tick)
  );

  i2cbe_shifter #(.DW(DW)) u_shift (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .load_i      (start && tx_mode_i),
    .load_data_i (wdata_i),
    .shift_i     (hi_end && !ack_slot),
    .sample_i    (hi_end && !ack_slot && !mode_q),
    .bit_i       (sda_i),
    .tx_msb_o    (tx_msb),
    .rx_data_o   (rdata_o)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q    <= ST_IDLE;
      slots_q <= '0;
      mode_q  <= 1'b0;
      ack_q   <= 1'b0;
      pend_q  <= 1'b0;
      irq_q   <= 1'b0;
      lrb_q   <= 1'b0;
    end else begin
      irq_q <= 1'b0;
      if (start) begin
        st_q    <= ST_LOW;
        mode_q  <= tx_mode_i;
        ack_q   <= ack_en_i;
        slots_q <= nb + SLOT_W'(ack_en_i);
        pend_q  <= 1'b0;
      end else if (st_q == ST_LOW && tick) begin
        st_q <= ST_HIGH;
      end else if (hi_end) begin
        lrb_q   <= sda_i;
        slots_q <= slots_q - SLOT_W'(1);
        if (last_slot) begin
          st_q   <= ST_HOLD;
          pend_q <= 1'b1;
          irq_q  <= 1'b1;
        end else begin
          st_q <= ST_LOW;
        end
      end
    end
  end

  p_hold_scl_low_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pend_o |-> !scl_o);
  p_irq_pulse_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o |=> !irq_o);
  p_sda_stable_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (scl_o && $past(scl_o) && busy_o && $past(busy_o)) |-> $stable(sda_oe_o));
  p_rx_ack_low_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (irq_o && !mode_q && ack_q) |-> $past(sda_oe_o));
  p_start_req_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(busy_o) |-> $past(wr_i || rd_i));
endmodule

// File: tb/i2c_byte_master_test.sv
module i2c_byte_master_test;
  localparam int CLK_P = 10;

  logic       clk, rst_n;
  logic [7:0] div_i;
  logic [2:0] bit_cnt_i;
  logic       ack_en_i, tx_mode_i, wr_i, rd_i;
  logic [7:0] wdata_i, rdata_o;
  logic       scl_o, sda_oe_o, busy_o, pend_o, irq_o, lrb_o;
  wire        sda_bus;
  logic       sl_pull;

  int nchk = 0, nbad = 0;
  int rcnt = 0, sidx = 0, irq_cnt = 0, tim_bad = 0, oe_bad = 0;
  int hi_len = 0, lo_len = 0, exp_div = 3, sl_base = 0;
  bit hi_valid = 0, lo_valid = 0, prev_scl = 1, prev_oe = 0;
  logic cap [64];
  logic [15:0] sl_vec = '1;

  assign sl_pull = !sl_vec[(sidx - sl_base) & 15];
  assign sda_bus = !(sda_oe_o || sl_pull);

  i2c_byte_master uut (
    .clk_i(clk), .rst_ni(rst_n), .div_i(div_i), .bit_cnt_i(bit_cnt_i),
    .ack_en_i(ack_en_i), .tx_mode_i(tx_mode_i), .wr_i(wr_i), .wdata_i(wdata_i),
    .rd_i(rd_i), .rdata_o(rdata_o), .scl_o(scl_o), .sda_oe_o(sda_oe_o),
    .sda_i(sda_bus), .busy_o(busy_o), .pend_o(pend_o), .irq_o(irq_o), .lrb_o(lrb_o)
  );

  initial clk = 0;
  always #(CLK_P/2) clk = ~clk;

  // bus monitor and slave index tracking
  always @(negedge clk) begin
    if (scl_o && !prev_scl) begin
      if (lo_valid && lo_len != exp_div) tim_bad++;
      cap[rcnt % 64] = sda_bus;
      rcnt++;
      hi_len = 1; hi_valid = 1;
    end else if (scl_o) hi_len++;
    if (!scl_o && prev_scl) begin
      if (hi_valid && hi_len != exp_div) tim_bad++;
      hi_valid = 0; lo_len = 1; lo_valid = 1; sidx = rcnt;
    end else if (!scl_o) lo_len++;
    if (pend_o) lo_valid = 0;
    if (scl_o && prev_scl && busy_o && sda_oe_o != prev_oe) oe_bad++;
    if (irq_o) irq_cnt++;
    prev_scl = scl_o; prev_oe = sda_oe_o;
  end

  initial begin
    repeat (150000) @(posedge clk);
    $display("FAIL watchdog expired");
    $display("  test done: total=%0d bad=%0d", nchk + 1, nbad + 1);
    $finish;
  end

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    nchk++;
    if (!ok) begin
      nbad++;
      $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
    end
  endtask

  task automatic wait_done(input int ib);
    int k = 0;
    while (!pend_o && k < 20000) begin @(negedge clk); k++; end
    chk(pend_o == 1, "R8 pend after transfer", pend_o, 1);
    repeat (3) @(negedge clk);
    chk(irq_cnt - ib == 1, "R8 single irq pulse", irq_cnt - ib, 1);
    chk(scl_o == 0 && pend_o == 1, "R8 scl held low while pending", {scl_o, pend_o}, 2'b01);
    chk(tim_bad == 0, "R9 scl phase length", tim_bad, 0);
    chk(oe_bad == 0, "R10 sda stable while scl high", oe_bad, 0);
  endtask

  task automatic do_tx(input logic [7:0] d, input logic [2:0] bc, input bit ack, input bit sack, input bit poke);
    int n = (bc == 0) ? 8 : int'(bc);
    int rb, ib;
    logic [7:0] got, exp;
    @(negedge clk);
    rb = rcnt; ib = irq_cnt; sl_base = sidx;
    sl_vec = '1;
    if (ack) sl_vec[n] = sack;
    bit_cnt_i = bc; ack_en_i = ack; tx_mode_i = 1; wdata_i = d; wr_i = 1;
    @(negedge clk); wr_i = 0;
    chk(busy_o == 1, "R4 write starts transfer", busy_o, 1);
    if (poke) begin
      repeat (6) @(negedge clk);
      wdata_i = ~d; wr_i = 1; rd_i = 1;
      @(negedge clk); wr_i = 0; rd_i = 0;
    end
    wait_done(ib);
    chk(rcnt - rb == n + int'(ack), "R2 R3 clock pulse count", rcnt - rb, n + int'(ack));
    got = '0; exp = '0;
    for (int k = 0; k < n; k++) begin got[7-k] = cap[(rb + k) % 64]; exp[7-k] = d[7-k]; end
    chk(got == exp, poke ? "R11 busy strobe ignored, data intact" : "R4 msb first data", got, exp);
    if (ack) chk(lrb_o == sack, "R5 ack captured in lrb", lrb_o, sack);
  endtask

  task automatic do_rx(input logic [7:0] sb, input logic [2:0] bc, input bit ack, input logic [7:0] exp_ret);
    int n = (bc == 0) ? 8 : int'(bc);
    int rb, ib;
    logic [7:0] ret, mask, expd;
    @(negedge clk);
    rb = rcnt; ib = irq_cnt; sl_base = sidx;
    sl_vec = '1;
    for (int k = 0; k < n; k++) sl_vec[k] = sb[7-k];
    bit_cnt_i = bc; ack_en_i = ack; tx_mode_i = 0; rd_i = 1;
    ret = rdata_o;
    @(negedge clk); rd_i = 0;
    chk(ret == exp_ret, "R6 read returns previous word", ret, exp_ret);
    chk(busy_o == 1, "R6 read starts reception", busy_o, 1);
    wait_done(ib);
    chk(rcnt - rb == n + int'(ack), "R2 R3 rx clock pulse count", rcnt - rb, n + int'(ack));
    mask = 8'((16'd1 << n) - 1);
    expd = 8'(sb >> (8 - n));
    chk((rdata_o & mask) == expd, "R6 received bits", rdata_o & mask, expd);
    if (ack) chk(cap[(rb + n) % 64] == 0, "R7 master acks low", cap[(rb + n) % 64], 0);
  endtask

  task automatic ignore_strobe(input bit use_wr, input bit txm, input string tag);
    @(negedge clk);
    tx_mode_i = txm; wdata_i = 8'h33;
    if (use_wr) wr_i = 1; else rd_i = 1;
    @(negedge clk); wr_i = 0; rd_i = 0;
    repeat (4) @(negedge clk);
    chk(busy_o == 0 && pend_o == 1 && scl_o == 0, tag, {busy_o, pend_o, scl_o}, 3'b010);
  endtask

  initial begin
    rst_n = 0; div_i = 8'd3; bit_cnt_i = 0; ack_en_i = 0; tx_mode_i = 1;
    wr_i = 0; rd_i = 0; wdata_i = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    chk(scl_o == 1 && sda_oe_o == 0 && busy_o == 0 && pend_o == 0 && irq_o == 0,
        "R1 reset state", {scl_o, sda_oe_o, busy_o, pend_o, irq_o}, 5'b10000);

    do_tx(8'hA5, 3'd0, 1, 0, 0);       // R4 R5 ack from slave
    do_tx(8'h3C, 3'd0, 1, 1, 0);       // R5 nack from slave
    do_tx(8'hC0, 3'd3, 0, 1, 0);       // R2 short word, R3 no ack slot
    do_tx(8'hF0, 3'd0, 0, 1, 1);       // R11 strobes during transfer

    do_rx(8'h96, 3'd0, 1, 8'h00);      // R6 dummy first read, R7
    do_rx(8'h5A, 3'd0, 0, 8'h96);      // R6 chained read
    do_rx(8'h80, 3'd1, 0, 8'h5A);      // R2 single bit
    chk(rdata_o == 8'hB5, "R6 bits shift toward msb", rdata_o, 8'hB5);

    ignore_strobe(1, 0, "R11 write in receive mode ignored");
    ignore_strobe(0, 1, "R11 read in transmit mode ignored");

    @(negedge clk); div_i = 8'd0; exp_div = 1;
    do_tx(8'h5A, 3'd0, 1, 0, 0);       // R9 zero divider acts as one
    @(negedge clk); div_i = 8'd5; exp_div = 5;
    do_tx(8'h81, 3'd7, 1, 0, 0);       // R9 longer phases, R2 seven bits

    $display("  test done: total=%0d bad=%0d", nchk, nbad);
    $finish;
  end
endmodule